// File: doc/BRIEF.md
# Rate-Half Convolutional Encoder (K = 3)

This block is a serial forward-error-correction encoder. Each clock it can take one data bit and turn it into a two-bit code symbol. The symbol depends on the new bit and on the two bits accepted before it. Those two past bits sit in a short history register, and their pair is the state of a four-state trellis.

The two parity outputs use generator taps 111 and 101 (octal 7 and 5). The symbol is registered and appears one clock after the bit is accepted, marked by its own valid strobe.

A flush request makes the encoder append two zero bits by itself. This brings the trellis back to state zero, so a downstream maximum-likelihood decoder can end its traceback in a known state. Constraint length, symbol width and generator taps are parameters. The defaults are the only configuration the requirements describe.

Top module: `conv_enc_r2`

## Requirements
- R1: While `rst` is high at a rising edge, the history register clears to state (m1,m2) = 00, `out_vld` goes low and `out_sym` goes to 00 on that edge.
- R2: A bit is accepted in a cycle when `in_vld` is high and no flush is in progress, or when a flush zero is injected. `out_vld` is high in exactly the cycle after each acceptance and low otherwise, so each accepted bit yields one two-bit symbol.
- R3: `out_sym[1]` (parity A) equals m0 XOR m1 XOR m2. Here m0 is the accepted bit, m1 the bit accepted before it and m2 the one before that.
- R4: `out_sym[0]` (parity B) equals m0 XOR m2; m1 has no influence on it.
- R5: After an acceptance the state (m1,m2) becomes (m0, old m1). From state 00 an input 1 gives symbol 11 and state 10, so a following input 0 gives symbol 10.
- R6: In a cycle with no acceptance the state holds, so the next accepted bit is encoded against unchanged history.
- R7: `flush_req` sampled high while no flush is in progress starts a flush. A data bit accepted in that same cycle is encoded first. Then, in the next two cycles, zero bits are accepted, each producing a valid symbol, and the state ends at 00.
- R8: While a flush is in progress, `in_vld`, `in_bit` and `flush_req` are ignored: the injected bits are zeros and no further flush is queued.
- R9: While `out_vld` is low, `out_sym` keeps the last symbol it carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Data bit strobe |
| in_bit | input | 1 | Data bit to encode |
| flush_req | input | 1 | Request to append two zero bits |
| out_vld | output | 1 | Symbol strobe, one clock after acceptance |
| out_sym | output | 2 | Code symbol; bit 1 is parity A (taps 111), bit 0 is parity B (taps 101) |

## Verification
A corrupted history bit shows up at the ports in the very next symbol. A wrong m1 flips parity A only. A wrong m2 flips both parities. Because parity A XOR parity B equals m1, any error in the shift path is visible within two accepted bits. A flush controller that miscounts leaves a non-zero state, so the first data symbol after the flush differs from the 11/00 pair expected from state 00. A bench reference model tracks the history and compares every output on every clock, so these faults are caught in the cycle they first reach `out_vld`/`out_sym`.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  // default code: constraint length 3, two parity outputs
  localparam int unsigned DEF_K     = 3;
  localparam int unsigned DEF_N_OUT = 2;
  // generator taps packed per output, output g at [g*K +: K];
  // tap bit 0 weighs the current bit, tap bit j the bit j acceptances back
  localparam logic [DEF_N_OUT*DEF_K-1:0] DEF_GENS = {3'b111, 3'b101};
endpackage

// File: rtl/conv_enc_hist.sv
module conv_enc_hist #(
  parameter int unsigned MEM = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv,
  input  logic           din,
  output logic [MEM-1:0] hist
);
  generate
    if (MEM == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)      hist <= '0;
        else if (adv) hist <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)      hist <= '0;
        else if (adv) hist <= {hist[MEM-2:0], din};
      end
    end
  endgenerate
endmodule

// File: rtl/conv_enc_taps.sv
module conv_enc_taps #(
  parameter int unsigned K     = 3,
  parameter int unsigned N_OUT = 2,
  parameter logic [N_OUT*K-1:0] GENS = {3'b111, 3'b101}
) (
  input  logic [K-1:0]     window,
  output logic [N_OUT-1:0] sym
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_par
    assign sym[g] = ^(window & GENS[g*K +: K]);
  end
endmodule

// File: rtl/conv_enc_flush.sv
module conv_enc_flush #(
  parameter int unsigned MEM   = 2,
  parameter int unsigned CNT_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic flush_req,
  output logic busy
);
  logic [CNT_W-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (busy)      cnt <= cnt - CNT_W'(1);
    else if (flush_req) cnt <= CNT_W'(MEM);
  end
endmodule

// File: rtl/conv_enc_r2.sv
module conv_enc_r2
  import conv_enc_pkg::*;
#(
  parameter int unsigned K     = DEF_K,
  parameter int unsigned N_OUT = DEF_N_OUT,
  parameter logic [N_OUT*K-1:0] GENS = DEF_GENS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_bit,
  input  logic             flush_req,
  output logic             out_vld,
  output logic [N_OUT-1:0] out_sym
);
  localparam int unsigned MEM   = K - 1;
  localparam int unsigned CNT_W = $clog2(MEM + 1);

  logic           busy;
  logic           adv;
  logic           cur_bit;
  logic [MEM-1:0] hist;
  logic [K-1:0]   window;
  logic [N_OUT-1:0] sym_nxt;

  // flush zeros take precedence over the data port
  assign adv     = busy | in_vld;
  assign cur_bit = busy ? 1'b0 : in_bit;
  assign window  = {hist, cur_bit};

  conv_enc_flush #(.MEM(MEM), .CNT_W(CNT_W)) u_flush (
    .clk(clk), .rst(rst), .flush_req(flush_req), .busy(busy)
  );

  conv_enc_hist #(.MEM(MEM)) u_hist (
    .clk(clk), .rst(rst), .adv(adv), .din(cur_bit), .hist(hist)
  );

  conv_enc_taps #(.K(K), .N_OUT(N_OUT), .GENS(GENS)) u_taps (
    .window(window), .sym(sym_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_sym <= '0;
    end else begin
      out_vld <= adv;
      if (adv) out_sym <= sym_nxt;
    end
  end
endmodule

// File: rtl/conv_enc_r2_chk.sv
module conv_enc_r2_chk #(
  parameter int unsigned MEM   = 2,
  parameter int unsigned N_OUT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             adv,
  input logic             busy,
  input logic             cur_bit,
  input logic [MEM-1:0]   hist,
  input logic             out_vld,
  input logic [N_OUT-1:0] out_sym
);
  // R1
  rst_clears_vld_chk: assert property (@(posedge clk) rst |=> (!out_vld && hist == '0));

  // R2
  accept_gives_vld_chk: assert property (@(posedge clk) disable iff (rst)
    adv |=> out_vld);

  // R2
  idle_no_vld_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> !out_vld);

  // R5
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    adv |=> hist[0] == $past(cur_bit));

  // R6
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !$past(rst)) |=> $stable(hist));

  // R3
  // R4
  parity_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !$past(rst)) |-> ((^out_sym) == $past(hist[0])));

  // R7
  flush_ends_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(busy)) |-> hist == '0);

  // R8
  flush_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(busy)) |=> busy);

  // R8
  flush_zero_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cur_bit);

  // R9
  sym_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_vld && !$past(rst)) |-> $stable(out_sym));
endmodule

bind conv_enc_r2 conv_enc_r2_chk #(.MEM(MEM), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .adv(adv), .busy(busy), .cur_bit(cur_bit),
  .hist(hist), .out_vld(out_vld), .out_sym(out_sym)
);

// File: tb/conv_enc_r2_tb_top.sv
`timescale 1ns/1ps
module conv_enc_r2_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0;
  logic       in_bit = 1'b0;
  logic       flush_req = 1'b0;
  logic       out_vld;
  logic [1:0] out_sym;

  always #10 clk = ~clk;   // 50 MHz

  conv_enc_r2 dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_bit(in_bit),
    .flush_req(flush_req), .out_vld(out_vld), .out_sym(out_sym)
  );

  // behavioural reference
  int    m1, m2, fc;
  int    exp_v, exp_a, exp_b;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    have_exp = 0;
  bit    done = 0;
  string tag = "R1";

  task automatic compare();
    n_vec++;
    if (out_vld !== 1'(exp_v)) begin
      n_bad++;
      $display("FAIL %s/R2 out_vld actual=%b expected=%0d", tag, out_vld, exp_v);
    end
    if (out_sym[1] !== 1'(exp_a)) begin
      n_bad++;
      $display("FAIL %s/%s parity A actual=%b expected=%0d", tag,
               exp_v ? "R3" : "R9", out_sym[1], exp_a);
    end
    if (out_sym[0] !== 1'(exp_b)) begin
      n_bad++;
      $display("FAIL %s/%s parity B actual=%b expected=%0d", tag,
               exp_v ? "R4" : "R9", out_sym[0], exp_b);
    end
  endtask

  task automatic step(input bit r, input bit v, input bit b, input bit f);
    int m0;
    bit acc;
    @(negedge clk);
    if (have_exp) compare();
    rst = r; in_vld = v; in_bit = b; flush_req = f;
    if (r) begin
      m1 = 0; m2 = 0; fc = 0; exp_v = 0; exp_a = 0; exp_b = 0;
    end else begin
      if (fc > 0) begin
        acc = 1; m0 = 0; fc--;
      end else begin
        acc = v; m0 = b;
        if (f) fc = 2;
      end
      if (acc) begin
        exp_a = m0 ^ m1 ^ m2;
        exp_b = m0 ^ m2;
        m2 = m1; m1 = m0;
        exp_v = 1;
      end else begin
        exp_v = 0;
      end
    end
    have_exp = 1;
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    // R5: from 00 input 1 -> 11, then input 0 -> 10
    tag = "R5";
    step(0, 1, 1, 0);
    step(0, 1, 0, 0);
    step(0, 0, 0, 0);

    // R6: gaps with toggling data bit do not disturb history
    tag = "R6";
    step(0, 1, 1, 0);
    for (int i = 0; i < 5; i++) step(0, 0, i[0], 0);
    step(0, 1, 1, 0);
    step(0, 0, 1, 0);
    step(0, 1, 0, 0);

    // R3 / R4: fixed patterns
    tag = "R3";
    step(0, 1, 1, 0); step(0, 1, 0, 0); step(0, 1, 1, 0);
    step(0, 1, 0, 0); step(0, 1, 0, 0);
    tag = "R4";
    for (int i = 0; i < 8; i++) step(0, 1, 1, 0);
    for (int i = 0; i < 8; i++) step(0, 1, i[1], 0);

    // R2: random data with random gaps
    tag = "R2";
    for (int i = 0; i < 300; i++) step(0, 1'($urandom_range(0, 3) != 0), 1'($urandom), 0);

    // R7: flush while idle, then check return to state 00
    tag = "R7";
    step(0, 1, 1, 0);
    step(0, 1, 1, 0);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    step(0, 1, 1, 0);
    // flush with a data bit in the same cycle
    step(0, 1, 1, 1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    step(0, 1, 1, 0);
    step(0, 1, 0, 0);

    // R8: inputs driven during flush are ignored
    tag = "R8";
    step(0, 1, 1, 0);
    step(0, 0, 0, 1);
    step(0, 1, 1, 1);
    step(0, 1, 1, 1);
    step(0, 0, 0, 0);
    step(0, 1, 1, 0);
    step(0, 0, 0, 0);

    // R9 and mixed traffic including flushes
    tag = "R9";
    for (int i = 0; i < 500; i++)
      step(0, 1'($urandom_range(0, 2) == 0), 1'($urandom), 1'($urandom_range(0, 15) == 0));

    // R1: reset in the middle of a stream and of a flush
    tag = "R1";
    step(0, 1, 1, 0);
    step(0, 1, 1, 1);
    step(1, 1, 1, 0);
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    step(0, 1, 1, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule